// File: doc/BRIEF.md
# Indirect Memory-Controller Configuration Register File

This block holds the software-visible configuration and status state of a DRAM memory controller. The whole set is reached through two slots on a simple register bus. One slot is an index slot: a write to it stores an internal offset, and a read of it returns that stored offset. The other is a window slot: a read or write there targets whichever internal register the stored offset names. Each internal register applies its own write rule. Some are masked stores. Some are write-one-to-clear. Some have side effects on neighbouring state. One is read-only.

Two outputs leave the block. The first is a memory-enable level, taken from the top bit of the configuration register, which gates the bank decoder. The second is a registered ECC interrupt that is high exactly while the ECC error register holds a nonzero value. The DRAM command sequencing is outside this block.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write to bus index 0x10 stores all 32 bits as the current offset, and a read of index 0x10 returns it. Read data appears on `bus_rdata` in the cycle after the read strobe. A read at any bus index other than 0x10 or 0x11 returns 0, and a write there changes nothing.
- R2: A write through the window to offset 0x00 or 0x08 (error status 0 and 1) clears each bit written as one and keeps the others. After reset both registers read 0.
- R3: Offset 0x10 (error address) stores and returns all 32 written bits.
- R4: A write to offset 0x20 (configuration) keeps only bits 31:21 and forces the rest to zero. `mem_enable` follows bit 31 of the stored configuration.
- R5: When a configuration write takes bit 31 from 0 to 1, status (offset 0x24) bit 31 clears. When it takes bit 31 from 1 to 0, that status bit sets. A write that leaves bit 31 unchanged leaves status bit 31 unchanged.
- R6: When a configuration write takes bit 30 from 0 to 1, status bit 30 sets. When it takes bit 30 from 1 to 0, status bit 30 clears.
- R7: A write to the status offset is ignored.
- R8: Refresh (offset 0x30) stores the written value AND 0x3FF80000. ECC configuration (offset 0x94) stores the written value AND 0x00F00000. Power management (offset 0x34) stores (value AND 0xF8000000) OR 0x07C00000.
- R9: ECC error status (offset 0x98) stores the written value AND 0xFFF0F000. `ecc_irq` rises in the cycle after a nonzero masked value is written over zero. It falls in the cycle after zero is written over a nonzero value. It stays high while one nonzero value replaces another.
- R10: After reset the registers hold the following values: configuration 0x00800000, refresh 0x05F00000, power management 0x07C00000, and every other register 0. `mem_enable` and `ecc_irq` are both low.
- R11: A window read of the timing offset 0x80, or of any offset that names no register, returns 0xFFFFFFFF.
- R12: Bank configuration register i sits at offset 0x40 + 4*i (offsets 0x40, 0x44, 0x48 and 0x4C with four banks). Each one stores the written value AND 0xFFDEE001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_idx | input | IDX_W | Register bus index of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| mem_enable | output | 1 | Global memory enable for the bank decoder |
| ecc_irq | output | 1 | Level ECC error interrupt |

## Verification
The bench builds the block with its default parameters: four banks, a 10-bit bus index, and the slots at 0x10 and 0x11. With four banks the last bank slot sits at 0x4C, so the bench can check the upper edge of the bank range. It also reads 0x50, the offset just past that range, and expects all ones. A bus index that is neither slot is included as well, so that the index decode is tested from both sides.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

    localparam logic [31:0] OFS_ERR0    = 32'h00;
    localparam logic [31:0] OFS_ERR1    = 32'h08;
    localparam logic [31:0] OFS_ERRADR  = 32'h10;
    localparam logic [31:0] OFS_CFG     = 32'h20;
    localparam logic [31:0] OFS_STAT    = 32'h24;
    localparam logic [31:0] OFS_REFR    = 32'h30;
    localparam logic [31:0] OFS_PWR     = 32'h34;
    localparam logic [31:0] OFS_BANK0   = 32'h40;
    localparam logic [31:0] OFS_TIMING  = 32'h80;
    localparam logic [31:0] OFS_ECCCFG  = 32'h94;
    localparam logic [31:0] OFS_ECCERR  = 32'h98;

    localparam logic [31:0] MASK_CFG    = 32'hFFE0_0000;
    localparam logic [31:0] MASK_REFR   = 32'h3FF8_0000;
    localparam logic [31:0] MASK_PWR    = 32'hF800_0000;
    localparam logic [31:0] FIX_PWR     = 32'h07C0_0000;
    localparam logic [31:0] MASK_ECCCFG = 32'h00F0_0000;
    localparam logic [31:0] MASK_ECCERR = 32'hFFF0_F000;
    localparam logic [31:0] MASK_BANK   = 32'hFFDE_E001;

    localparam logic [31:0] RST_CFG     = 32'h0080_0000;
    localparam logic [31:0] RST_REFR    = 32'h05F0_0000;
    localparam logic [31:0] RST_PWR     = 32'h07C0_0000;

    localparam int EN_BIT = 31;
    localparam int SR_BIT = 30;

    typedef struct packed {
        logic [31:0] err0;
        logic [31:0] err1;
        logic [31:0] erradr;
        logic [31:0] cfg;
        logic [31:0] stat;
        logic [31:0] refr;
        logic [31:0] pwr;
        logic [31:0] ecccfg;
        logic [31:0] eccerr;
    } regs_t;

    function automatic logic [31:0] bank_ofs(input int idx);
        return OFS_BANK0 + 32'(4 * idx);
    endfunction

    function automatic logic is_named(input logic [31:0] ofs, input int nbank);
        logic hit;
        hit = (ofs == OFS_ERR0) || (ofs == OFS_ERR1) || (ofs == OFS_ERRADR) ||
              (ofs == OFS_CFG) || (ofs == OFS_STAT) || (ofs == OFS_REFR) ||
              (ofs == OFS_PWR) || (ofs == OFS_ECCCFG) || (ofs == OFS_ECCERR);
        for (int i = 0; i < nbank; i++) begin
            if (ofs == bank_ofs(i)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/memctl_cfg_core.sv
module memctl_cfg_core
    import memctl_cfg_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    win_wr,
    input  logic [31:0]             win_ofs,
    input  logic [31:0]             win_wdata,
    output regs_t                   regs,
    output logic [NBANK-1:0][31:0]  banks,
    output logic                    irq
);

    logic [31:0] cfg_new;
    logic [31:0] ecc_new;
    assign cfg_new = win_wdata & MASK_CFG;
    assign ecc_new = win_wdata & MASK_ECCERR;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '{err0: '0, err1: '0, erradr: '0, cfg: RST_CFG, stat: '0,
                      refr: RST_REFR, pwr: RST_PWR, ecccfg: '0, eccerr: '0};
            irq  <= 1'b0;
        end else if (win_wr) begin
            case (win_ofs)
                OFS_ERR0:   regs.err0   <= regs.err0 & ~win_wdata;
                OFS_ERR1:   regs.err1   <= regs.err1 & ~win_wdata;
                OFS_ERRADR: regs.erradr <= win_wdata;
                OFS_CFG: begin
                    if (!regs.cfg[EN_BIT] && cfg_new[EN_BIT])
                        regs.stat[EN_BIT] <= 1'b0;
                    else if (regs.cfg[EN_BIT] && !cfg_new[EN_BIT])
                        regs.stat[EN_BIT] <= 1'b1;
                    if (!regs.cfg[SR_BIT] && cfg_new[SR_BIT])
                        regs.stat[SR_BIT] <= 1'b1;
                    else if (regs.cfg[SR_BIT] && !cfg_new[SR_BIT])
                        regs.stat[SR_BIT] <= 1'b0;
                    regs.cfg <= cfg_new;
                end
                OFS_REFR:   regs.refr   <= win_wdata & MASK_REFR;
                OFS_PWR:    regs.pwr    <= (win_wdata & MASK_PWR) | FIX_PWR;
                OFS_ECCCFG: regs.ecccfg <= win_wdata & MASK_ECCCFG;
                OFS_ECCERR: begin
                    if (regs.eccerr == '0 && ecc_new != '0)
                        irq <= 1'b1;
                    else if (regs.eccerr != '0 && ecc_new == '0)
                        irq <= 1'b0;
                    regs.eccerr <= ecc_new;
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                banks[g] <= '0;
            else if (win_wr && win_ofs == bank_ofs(g))
                banks[g] <= win_wdata & MASK_BANK;
        end
    end

    AST_IRQ_FOLLOWS_ERR: assert property (@(posedge clk) disable iff (rst)
        irq == (regs.eccerr != '0)); // R9
    AST_STAT_RO: assert property (@(posedge clk) disable iff (rst)
        (win_wr && win_ofs == OFS_STAT) |=> $stable(regs.stat)); // R7
    AST_EN_RISE_CLR: assert property (@(posedge clk) disable iff (rst)
        $rose(regs.cfg[EN_BIT]) |-> !regs.stat[EN_BIT]); // R5
    AST_EN_FALL_SET: assert property (@(posedge clk) disable iff (rst)
        $fell(regs.cfg[EN_BIT]) |-> regs.stat[EN_BIT]); // R5
    AST_SR_RISE_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(regs.cfg[SR_BIT]) |-> regs.stat[SR_BIT]); // R6
    AST_CFG_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        regs.cfg[20:0] == '0); // R4
    AST_PWR_FIXED: assert property (@(posedge clk) disable iff (rst)
        regs.pwr[26:0] == FIX_PWR[26:0]); // R8

endmodule

// File: rtl/memctl_cfg_rdmux.sv
module memctl_cfg_rdmux
    import memctl_cfg_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic [31:0]             ofs,
    input  regs_t                   regs,
    input  logic [NBANK-1:0][31:0]  banks,
    output logic [31:0]             value
);

    always_comb begin
        case (ofs)
            OFS_ERR0:   value = regs.err0;
            OFS_ERR1:   value = regs.err1;
            OFS_ERRADR: value = regs.erradr;
            OFS_CFG:    value = regs.cfg;
            OFS_STAT:   value = regs.stat;
            OFS_REFR:   value = regs.refr;
            OFS_PWR:    value = regs.pwr;
            OFS_TIMING: value = '1;
            OFS_ECCCFG: value = regs.ecccfg;
            OFS_ECCERR: value = regs.eccerr;
            default:    value = '1;
        endcase
        for (int i = 0; i < NBANK; i++) begin
            if (ofs == bank_ofs(i)) value = banks[i];
        end
    end

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
    import memctl_cfg_pkg::*;
#(
    parameter int              NBANK    = 4,
    parameter int              IDX_W    = 10,
    parameter logic [IDX_W-1:0] IDX_ADDR = IDX_W'(16'h010),
    parameter logic [IDX_W-1:0] IDX_DATA = IDX_W'(16'h011)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             mem_enable,
    output logic             ecc_irq
);

    logic [31:0]            ofs_q;
    logic                   sel_addr;
    logic                   sel_data;
    regs_t                  regs;
    logic [NBANK-1:0][31:0] banks;
    logic [31:0]            win_val;

    assign sel_addr = (bus_idx == IDX_ADDR);
    assign sel_data = (bus_idx == IDX_DATA);

    always_ff @(posedge clk) begin
        if (rst)
            ofs_q <= '0;
        else if (bus_wr && sel_addr)
            ofs_q <= bus_wdata;
    end

    memctl_cfg_core #(.NBANK(NBANK)) u_core (
        .clk       (clk),
        .rst       (rst),
        .win_wr    (bus_wr && sel_data),
        .win_ofs   (ofs_q),
        .win_wdata (bus_wdata),
        .regs      (regs),
        .banks     (banks),
        .irq       (ecc_irq)
    );

    memctl_cfg_rdmux #(.NBANK(NBANK)) u_rdmux (
        .ofs   (ofs_q),
        .regs  (regs),
        .banks (banks),
        .value (win_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd) begin
            if (sel_addr)      bus_rdata <= ofs_q;
            else if (sel_data) bus_rdata <= win_val;
            else               bus_rdata <= '0;
        end
    end

    assign mem_enable = regs.cfg[EN_BIT];

    AST_UNNAMED_ONES: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel_data && !is_named(ofs_q, NBANK) && ofs_q != OFS_TIMING)
        |=> bus_rdata == '1); // R11
    AST_FOREIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !sel_addr && !sel_data) |=> bus_rdata == '0); // R1
    AST_ADDR_READBACK: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel_addr) |=> bus_rdata == $past(ofs_q)); // R1

endmodule

// File: tb/memctl_cfg_regs_tb.sv
module memctl_cfg_regs_tb;

    localparam logic [9:0] IA = 10'h010;
    localparam logic [9:0] ID = 10'h011;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  bus_idx;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        mem_enable;
    logic        ecc_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    memctl_cfg_regs u_dut (
        .clk(clk), .rst(rst), .bus_idx(bus_idx), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_enable(mem_enable), .ecc_irq(ecc_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] idx, input logic [31:0] d);
        bus_idx = idx; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] idx, input logic [31:0] exp, input string tag);
        bus_idx = idx; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wreg(input logic [31:0] ofs, input logic [31:0] d);
        wr(IA, ofs);
        wr(ID, d);
    endtask

    task automatic rreg(input logic [31:0] ofs, input logic [31:0] exp, input string tag);
        wr(IA, ofs);
        rd(ID, exp, tag);
    endtask

    // monitor: a read strobe seen at an edge yields data by the next falling edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() != 0) begin
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(20000 * 10);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_idx = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10 mem_enable", {31'b0, mem_enable}, 32'h0);
        check("R10 ecc_irq", {31'b0, ecc_irq}, 32'h0);
        rd(IA, 32'h0, "R10 offset reset");
        rreg(32'h20, 32'h0080_0000, "R10 cfg reset");
        rreg(32'h30, 32'h05F0_0000, "R10 refresh reset");
        rreg(32'h34, 32'h07C0_0000, "R10 pwr reset");
        rreg(32'h24, 32'h0, "R10 status reset");
        rreg(32'h98, 32'h0, "R10 ecc err reset");
        rreg(32'h48, 32'h0, "R10 bank2 reset");

        // R1 index slot and foreign indices
        wr(IA, 32'h1234_5678);
        rd(IA, 32'h1234_5678, "R1 offset readback");
        rd(10'h005, 32'h0, "R1 foreign read");
        wr(10'h005, 32'hFFFF_FFFF);
        rreg(32'h20, 32'h0080_0000, "R1 foreign write ignored");

        // R3 error address
        wreg(32'h10, 32'hDEAD_BEEF);
        rreg(32'h10, 32'hDEAD_BEEF, "R3 error address");

        // R2 write-one-to-clear
        wreg(32'h00, 32'hFFFF_FFFF);
        rreg(32'h00, 32'h0, "R2 err0 clear");
        wreg(32'h08, 32'h0F0F_0F0F);
        rreg(32'h08, 32'h0, "R2 err1 clear");

        // R4 R5 R6 configuration and status edges
        wreg(32'h20, 32'hFFFF_FFFF);
        check("R4 mem_enable on", {31'b0, mem_enable}, 32'h1);
        rd(ID, 32'hFFE0_0000, "R4 cfg mask");
        rreg(32'h24, 32'h4000_0000, "R6 rise sets bit30");
        wreg(32'h20, 32'h0);
        check("R4 mem_enable off", {31'b0, mem_enable}, 32'h0);
        rreg(32'h24, 32'h8000_0000, "R5 fall sets bit31 R6 fall clears bit30");
        wreg(32'h20, 32'h8000_0000);
        rreg(32'h24, 32'h0, "R5 rise clears bit31");
        wreg(32'h20, 32'h8000_0000);
        rreg(32'h24, 32'h0, "R5 no edge no change");
        wreg(32'h20, 32'h4000_0000);
        rreg(32'h24, 32'hC000_0000, "R5 R6 simultaneous edges");

        // R7 status read-only
        wreg(32'h24, 32'h0);
        rreg(32'h24, 32'hC000_0000, "R7 status write ignored");

        // R8 masked stores
        wreg(32'h30, 32'hFFFF_FFFF);
        rreg(32'h30, 32'h3FF8_0000, "R8 refresh mask");
        wreg(32'h34, 32'hFFFF_FFFF);
        rreg(32'h34, 32'hFFC0_0000, "R8 pwr ones");
        wreg(32'h34, 32'h0);
        rreg(32'h34, 32'h07C0_0000, "R8 pwr zero");
        wreg(32'h94, 32'hFFFF_FFFF);
        rreg(32'h94, 32'h00F0_0000, "R8 ecc cfg mask");

        // R11 all-ones reads
        wreg(32'h80, 32'h0);
        rreg(32'h80, 32'hFFFF_FFFF, "R11 timing reads ones");
        rreg(32'h04, 32'hFFFF_FFFF, "R11 unnamed 0x04");
        rreg(32'h50, 32'hFFFF_FFFF, "R11 past last bank");

        // R12 bank registers
        for (int i = 0; i < 4; i++) begin
            wreg(32'h40 + 32'(4 * i), 32'hFFFF_FFFF);
        end
        for (int i = 0; i < 4; i++) begin
            rreg(32'h40 + 32'(4 * i), 32'hFFDE_E001, "R12 bank mask");
        end
        wreg(32'h4C, 32'h1234_5678);
        rreg(32'h4C, 32'h1214_4000, "R12 last bank pattern");
        rreg(32'h40, 32'hFFDE_E001, "R12 bank0 untouched");

        // R9 ECC error and interrupt
        wreg(32'h98, 32'h0000_F000);
        check("R9 irq rises", {31'b0, ecc_irq}, 32'h1);
        rd(ID, 32'h0000_F000, "R9 ecc err value");
        wreg(32'h98, 32'h000F_0FFF);
        check("R9 irq falls on masked zero", {31'b0, ecc_irq}, 32'h0);
        rd(ID, 32'h0, "R9 ecc err masked zero");
        wreg(32'h98, 32'hFFFF_FFFF);
        check("R9 irq rises again", {31'b0, ecc_irq}, 32'h1);
        rd(ID, 32'hFFF0_F000, "R9 ecc err mask");
        wreg(32'h98, 32'h0010_0000);
        check("R9 irq holds", {31'b0, ecc_irq}, 32'h1);
        rd(ID, 32'h0010_0000, "R9 ecc err replace");
        wreg(32'h98, 32'h0);
        check("R9 irq falls", {31'b0, ecc_irq}, 32'h0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R1 reads drained", 32'(exp_q.size()), 32'h0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule